// File: doc/BRIEF.md
# SDRAM Precharge Rule Checker

A passive monitor for a four-bank synchronous DRAM command bus. It samples the chip-select, row/column strobes, write enable, two bank-address bits, the auto-precharge address bit, the data mask and a read-data-present strobe on every rising clock edge. It never drives the memory. It reports any breach of the rules that govern how precharge interacts with bursts of length four. These rules cover early precharge after written data, unmasked data left over after a same-bank precharge cuts a write short, missing idle cycles when the bus turns from read to write, read data that appears or is missing after a precharge, column commands that interrupt an auto-precharge burst, and row activates that come too soon after an auto precharge.

Column latency (2 or 3), the last-data-to-precharge spacing and the precharge-to-activate time are parameters. A violation produces a one-cycle pulse with a 3-bit cause code. A sticky flag and the code of the first violation stay set until reset.

Top module: `sdram_precharge_monitor`

## Requirements
- R1: After reset, err_pulse, err_code, err_seen and first_code are all 0, and all per-bank burst, auto-precharge and timer state is cleared.
- R2: A precharge to bank B sampled fewer than T_RDL cycles after the last unmasked, non-truncated write beat to bank B is cause code 1. The distance is 0 when the beat falls in the precharge cycle. Write beats occur in the write command cycle and the three cycles after it, until a read or write command ends the burst. A precharge to any other bank is not checked against bank B's data.
- R3: A precharge to the bank of a running write burst truncates it. Every later beat of that burst must have dqm high, and an unmasked one is cause code 2. A precharge to another bank leaves the burst intact.
- R4: An unmasked write beat sampled in a cycle where rd_strobe is high, or where it was high in the previous cycle, is a bus contention, cause code 3.
- R5: A read issued at cycle t places column beats at t..t+3. A later read or write ends them, and so does a precharge to the read's bank, from the precharge cycle on. rd_strobe must be high exactly CAS_LAT cycles after each surviving column beat. This leaves CAS_LAT-1 valid beats after a late precharge. Any difference is cause code 4. A precharge to another bank does not shorten the read.
- R6: After a read or write with auto_pre high at cycle t, any read or write to any bank at cycles t+1..t+3 is cause code 5. From t+4 on, column commands are legal.
- R7: After a column command with auto_pre high to bank B at cycle t, an activate to bank B before cycle t+4+T_RP is cause code 6. Activates to other banks are unaffected.
- R8: Commands decode from {cs_n,ras_n,cas_n,we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge; anything else is ignored. A violation sampled at edge E raises err_pulse with err_code for the cycle after E only. When several causes coincide, the lowest code is reported. err_seen and first_code latch the first reported code and hold it until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 2 | Bank address of the command |
| auto_pre | input | 1 | Auto-precharge request bit of a column command |
| dqm | input | 1 | Data mask; high masks the write beat of that cycle |
| rd_strobe | input | 1 | Read data present on the bus this cycle |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Cause code while err_pulse is high, else 0 |
| err_seen | output | 1 | Sticky: a violation has occurred since reset |
| first_code | output | 3 | Cause code of the first violation since reset |

## Verification
The hardest situations to reach are those that depend on the exact cycle where two schedules meet. Examples are a precharge that cuts a read at different offsets, so the surviving beat count shifts with CAS_LAT, and a write whose first unmasked beat falls just before or just after the end of the read data. The bench draws the precharge position, the unmasked beat position, the write start and the mask release point from $urandom with a fixed seed. It drives rd_strobe from its own beat schedule. Directed runs pin the exact boundary cycles: t+3 versus t+4 for column commands, t+4+T_RP-1 versus t+4+T_RP for activates, and a distance of T_RDL-1 versus T_RDL for precharge.

// File: rtl/sdram_precharge_monitor.sv
module sdram_precharge_monitor #(
  parameter int CAS_LAT = 2,
  parameter int T_RDL   = 2,
  parameter int T_RP    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] bank,
  input  logic       auto_pre,
  input  logic       dqm,
  input  logic       rd_strobe,
  output logic       err_pulse,
  output logic [2:0] err_code,
  output logic       err_seen,
  output logic [2:0] first_code
);
  localparam int GAPW    = $clog2(T_RDL + 1);
  localparam int RP_LOAD = T_RP + 3;
  localparam int RPW     = $clog2(RP_LOAD + 1);

  logic is_act, is_rd, is_wr, is_pre, is_col;
  assign is_act = ~cs_n & ~ras_n &  cas_n &  we_n;
  assign is_rd  = ~cs_n &  ras_n & ~cas_n &  we_n;
  assign is_wr  = ~cs_n &  ras_n & ~cas_n & ~we_n;
  assign is_pre = ~cs_n & ~ras_n &  cas_n & ~we_n;
  assign is_col = is_rd | is_wr;

  // write burst tracking
  logic [1:0] wr_left, wr_bank;
  logic       wr_cut;
  logic       wr_tail, wr_drive, wr_written;
  logic [1:0] beat_bank;
  assign wr_tail    = (wr_left != 2'd0) & ~is_col;
  assign beat_bank  = is_wr ? bank : wr_bank;
  assign wr_drive   = (is_wr | wr_tail) & ~dqm;
  assign wr_written = (is_wr | (wr_tail & ~wr_cut)) & ~dqm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_left <= '0;
      wr_bank <= '0;
      wr_cut  <= 1'b0;
    end else if (is_wr) begin
      wr_left <= 2'd3;
      wr_bank <= bank;
      wr_cut  <= 1'b0;
    end else if (is_rd) begin
      wr_left <= '0;
      wr_cut  <= 1'b0;
    end else if (wr_left != 2'd0) begin
      wr_left <= wr_left - 2'd1;
      if (is_pre && bank == wr_bank) wr_cut <= 1'b1;
    end
  end

  // last-data-in distance per bank, saturating at T_RDL
  logic [GAPW-1:0] gap_q   [4];
  logic [GAPW-1:0] cur_gap [4];
  always_comb
    for (int i = 0; i < 4; i++)
      cur_gap[i] = (wr_written && beat_bank == 2'(i)) ? '0 : gap_q[i];

  always_ff @(posedge clk)
    for (int i = 0; i < 4; i++)
      if (!rst_n) gap_q[i] <= GAPW'(T_RDL);
      else if (cur_gap[i] < GAPW'(T_RDL)) gap_q[i] <= cur_gap[i] + 1'b1;
      else gap_q[i] <= GAPW'(T_RDL);

  // read burst tracking and expected strobe
  logic [1:0] rd_left, rd_bank;
  logic       rd_col, rd_kill, rd_strobe_q;
  logic [CAS_LAT-1:0] rd_pipe;
  assign rd_kill = is_wr | (is_pre & bank == rd_bank);
  assign rd_col  = is_rd | ((rd_left != 2'd0) & ~rd_kill);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_left     <= '0;
      rd_bank     <= '0;
      rd_pipe     <= '0;
      rd_strobe_q <= 1'b0;
    end else begin
      rd_pipe     <= {rd_pipe[CAS_LAT-2:0], rd_col};
      rd_strobe_q <= rd_strobe;
      if (is_rd) begin
        rd_left <= 2'd3;
        rd_bank <= bank;
      end else if (rd_kill) rd_left <= '0;
      else if (rd_left != 2'd0) rd_left <= rd_left - 2'd1;
    end
  end

  // auto precharge: column lockout and per-bank activate timer
  logic [1:0]     ap_busy;
  logic [RPW-1:0] rp_q [4];
  always_ff @(posedge clk) begin
    if (!rst_n) ap_busy <= '0;
    else if (is_col && auto_pre) ap_busy <= 2'd3;
    else if (ap_busy != 2'd0) ap_busy <= ap_busy - 2'd1;
  end

  always_ff @(posedge clk)
    for (int i = 0; i < 4; i++)
      if (!rst_n) rp_q[i] <= '0;
      else if (is_col && auto_pre && bank == 2'(i)) rp_q[i] <= RPW'(RP_LOAD);
      else if (rp_q[i] != '0) rp_q[i] <= rp_q[i] - 1'b1;

  // rule evaluation
  logic err_rdl, err_cut, err_cont, err_rdv, err_cas, err_act;
  assign err_rdl  = is_pre & (cur_gap[bank] < GAPW'(T_RDL));
  assign err_cut  = wr_tail & wr_cut & ~dqm;
  assign err_cont = wr_drive & (rd_strobe | rd_strobe_q);
  assign err_rdv  = rd_strobe ^ rd_pipe[CAS_LAT-1];
  assign err_cas  = is_col & (ap_busy != 2'd0);
  assign err_act  = is_act & (rp_q[bank] != '0);

  logic [2:0] cause;
  always_comb begin
    if (err_rdl)       cause = 3'd1;
    else if (err_cut)  cause = 3'd2;
    else if (err_cont) cause = 3'd3;
    else if (err_rdv)  cause = 3'd4;
    else if (err_cas)  cause = 3'd5;
    else if (err_act)  cause = 3'd6;
    else               cause = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_code   <= '0;
      err_seen   <= 1'b0;
      first_code <= '0;
    end else begin
      err_pulse <= cause != 3'd0;
      err_code  <= cause;
      if (!err_seen && cause != 3'd0) begin
        err_seen   <= 1'b1;
        first_code <= cause;
      end
    end
  end

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> err_seen && $stable(first_code));
  a_r8_first_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |-> first_code != 3'd0);
  a_r8_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_seen);
  a_r3_cut_beat_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cut && wr_tail && !dqm) |=> err_pulse && err_code <= 3'd2);
  a_r5_strobe_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe != rd_pipe[CAS_LAT-1]) |=> err_pulse);
  a_r6_cas_in_ap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && ap_busy != 2'd0) |=> err_pulse);
  a_r7_act_early: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && rp_q[bank] != '0) |=> err_pulse);
  a_r4_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drive && rd_strobe) |=> err_pulse && err_code <= 3'd3);
endmodule

// File: tb/tb_sdram_precharge_monitor.sv
`timescale 1ns/1ps
module tb_sdram_precharge_monitor;
  localparam int CL = 2, TRDL = 2, TRP = 3;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                         WR = 4'b0100, PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic auto_pre = 1'b0, dqm = 1'b1, rd_strobe = 1'b0;
  logic err_pulse, err_seen;
  logic [2:0] err_code, first_code;
  logic [7:0] mask;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sdram_precharge_monitor #(.CAS_LAT(CL), .T_RDL(TRDL), .T_RP(TRP)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cmd[3]), .ras_n(cmd[2]), .cas_n(cmd[1]),
    .we_n(cmd[0]), .bank(bank), .auto_pre(auto_pre), .dqm(dqm),
    .rd_strobe(rd_strobe), .err_pulse(err_pulse), .err_code(err_code),
    .err_seen(err_seen), .first_code(first_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] c, input logic [1:0] b, input logic a,
                      input logic m, input logic r);
    cmd = c; bank = b; auto_pre = a; dqm = m; rd_strobe = r;
    @(posedge clk); #1;
    if (rst_n && err_pulse) mask[err_code] = 1'b1;
  endtask

  task automatic finish_scn(input logic [7:0] exp, input string req);
    for (int i = 0; i < 10; i++) tick(NOP, 2'd0, 1'b0, 1'b1, 1'b0);
    chk(mask == exp, req, mask, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd = NOP; rd_strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_rdl(int g, bit other);
    return (!other && g < TRDL) ? 8'h02 : 8'h00;
  endfunction
  function automatic logic [7:0] exp_cut(int p, int q, bit other);
    if (other) return 8'h00;
    if (q > p) return 8'h04;
    return ((p - q) < TRDL) ? 8'h02 : 8'h00;
  endfunction
  function automatic logic [7:0] exp_cont(int g, int u);
    int last;
    last = ((g < 4) ? g : 4) - 1 + CL;
    return (u <= last + 1) ? 8'h08 : 8'h00;
  endfunction
  function automatic logic rd_beat(int j, int stop);
    int c;
    c = j - CL;
    return (c >= 0 && c < 4 && c < stop);
  endfunction

  // R2: precharge spacing after last written beat
  task automatic scn_rdl(input logic [1:0] b, input int g, input bit other);
    mask = 0;
    for (int j = 0; j <= 3 + g; j++)
      if (j == 3 + g) tick(PRE, other ? b ^ 2'd1 : b, 1'b0, 1'b0, 1'b0);
      else if (j == 0) tick(WR, b, 1'b0, 1'b0, 1'b0);
      else tick(NOP, 2'd0, 1'b0, 1'b0, 1'b0);
    finish_scn(exp_rdl(g, other), "R2 precharge after write data");
  endtask

  // R3: truncated write needs masked tail
  task automatic scn_cut(input logic [1:0] b, input int p, input int q, input bit other);
    mask = 0;
    for (int j = 0; j < 4; j++)
      if (j == 0) tick(WR, b, 1'b0, (j != q), 1'b0);
      else if (j == p) tick(PRE, other ? b ^ 2'd2 : b, 1'b0, (j != q), 1'b0);
      else tick(NOP, 2'd0, 1'b0, (j != q), 1'b0);
    finish_scn(exp_cut(p, q, other), "R3 truncated write mask");
  endtask

  // R4: read to write turnaround
  task automatic scn_cont(input int g, input int u);
    int last;
    mask = 0;
    last = (g + 3 > 7) ? g + 3 : 7;
    for (int j = 0; j <= last; j++) begin
      logic m;
      m = (j >= g && j <= g + 3) ? (j < u) : 1'b1;
      if (j == 0) tick(RD, 2'd0, 1'b0, m, rd_beat(j, (g < 4) ? g : 4));
      else if (j == g) tick(WR, 2'd0, 1'b0, m, rd_beat(j, (g < 4) ? g : 4));
      else tick(NOP, 2'd0, 1'b0, m, rd_beat(j, (g < 4) ? g : 4));
    end
    finish_scn(exp_cont(g, u), "R4 turnaround gap");
  endtask

  // R5: read beats surviving a precharge
  task automatic scn_rcut(input logic [1:0] b, input int p, input bit same,
                          input bit flip, input int fj);
    mask = 0;
    for (int j = 0; j < 10; j++) begin
      logic r;
      r = rd_beat(j, same ? p : 4) ^ (flip && j == fj);
      if (j == 0) tick(RD, b, 1'b0, 1'b1, r);
      else if (j == p) tick(PRE, same ? b : b ^ 2'd1, 1'b0, 1'b1, r);
      else tick(NOP, 2'd0, 1'b0, 1'b1, r);
    end
    finish_scn(flip ? 8'h10 : 8'h00, "R5 read beats after precharge");
  endtask

  // R6: column command during auto-precharge burst
  task automatic scn_apcas(input int k, input logic [1:0] wb);
    mask = 0;
    for (int j = 0; j < 10; j++) begin
      logic r;
      r = rd_beat(j, (k < 4) ? k : 4);
      if (j == 0) tick(RD, 2'd0, 1'b1, 1'b1, r);
      else if (j == k) tick(WR, wb, 1'b0, 1'b1, r);
      else tick(NOP, 2'd0, 1'b0, 1'b1, r);
    end
    finish_scn((k < 4) ? 8'h20 : 8'h00, "R6 column during auto precharge");
  endtask

  // R7: activate after auto precharge
  task automatic scn_apact(input int d, input bit same);
    mask = 0;
    for (int j = 0; j <= d; j++)
      if (j == 0) tick(WR, 2'd3, 1'b1, 1'b1, 1'b0);
      else if (j == d) tick(ACT, same ? 2'd3 : 2'd1, 1'b0, 1'b1, 1'b0);
      else tick(NOP, 2'd0, 1'b0, 1'b1, 1'b0);
    finish_scn((same && d < 4 + TRP) ? 8'h40 : 8'h00, "R7 activate after auto precharge");
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    // R1 reset state
    chk(err_pulse == 1'b0, "R1 err_pulse", err_pulse, 0);
    chk(err_code == 3'd0, "R1 err_code", err_code, 0);
    chk(err_seen == 1'b0, "R1 err_seen", err_seen, 0);
    chk(first_code == 3'd0, "R1 first_code", first_code, 0);
    mask = 0;
    finish_scn(8'h00, "R1 idle bus quiet");

    scn_rdl(2'd1, 1, 1'b0);
    scn_rdl(2'd1, 2, 1'b0);
    scn_rdl(2'd2, 0, 1'b1);
    for (int i = 0; i < 8; i++) scn_rdl(2'($urandom % 4), $urandom % 5, ($urandom % 3) == 0);

    scn_cut(2'd0, 1, 2, 1'b0);
    scn_cut(2'd0, 1, 2, 1'b1);
    scn_cut(2'd3, 2, 0, 1'b0);
    for (int i = 0; i < 8; i++) scn_cut(2'($urandom % 4), 1 + $urandom % 3, $urandom % 4, ($urandom % 4) == 0);

    scn_cont(3, 5);
    scn_cont(3, 6);
    for (int i = 0; i < 8; i++) begin
      int g;
      g = 1 + $urandom % 6;
      scn_cont(g, g + $urandom % 4);
    end

    scn_rcut(2'd1, 4, 1'b1, 1'b0, 0);
    scn_rcut(2'd1, 2, 1'b0, 1'b0, 0);
    scn_rcut(2'd2, 2, 1'b1, 1'b1, 4);
    for (int i = 0; i < 8; i++)
      scn_rcut(2'($urandom % 4), 1 + $urandom % 6, $urandom % 2, ($urandom % 4) == 0, 2 + $urandom % 7);

    scn_apcas(3, 2'd1);
    scn_apcas(4, 2'd0);
    for (int i = 0; i < 6; i++) scn_apcas(1 + $urandom % 5, 2'($urandom % 4));

    scn_apact(4 + TRP - 1, 1'b1);
    scn_apact(4 + TRP, 1'b1);
    scn_apact(2, 1'b0);
    for (int i = 0; i < 6; i++) scn_apact(1 + $urandom % 10, ($urandom % 3) != 0);

    // R8 pulse timing, priority and sticky capture
    do_reset();
    tick(NOP, 2'd0, 1'b0, 1'b1, 1'b0);
    chk(err_pulse == 1'b0, "R8 quiet before violation", err_pulse, 0);
    tick(WR, 2'd0, 1'b0, 1'b0, 1'b1);
    chk(err_pulse == 1'b1, "R8 pulse after violating edge", err_pulse, 1);
    chk(err_code == 3'd3, "R8 lowest code wins", err_code, 3);
    tick(NOP, 2'd0, 1'b0, 1'b1, 1'b0);
    chk(err_pulse == 1'b0, "R8 pulse lasts one cycle", err_pulse, 0);
    chk(err_seen == 1'b1 && first_code == 3'd3, "R8 sticky first code", first_code, 3);
    for (int j = 0; j < 4; j++) tick(NOP, 2'd0, 1'b0, 1'b1, 1'b0);
    tick(RD, 2'd1, 1'b1, 1'b1, 1'b0);
    tick(RD, 2'd1, 1'b0, 1'b1, 1'b0);
    chk(err_pulse == 1'b1 && err_code == 3'd5, "R8 later violation reported", err_code, 5);
    chk(first_code == 3'd3, "R8 first code held", first_code, 3);
    do_reset();
    chk(err_seen == 1'b0 && first_code == 3'd0, "R1 reset clears sticky", first_code, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule